// File: doc/BRIEF.md
# Reloadable Down-Counting Timer Channel

This block is a single timer channel on a small register bus. Software sets a start value, picks a tick source and a counting mode, and enables the channel. On each selected tick the counter drops by one. The step after zero is an underflow. In periodic mode an underflow restarts the count from the stored start value. In free mode it wraps to all ones. Every underflow raises a level interrupt. The interrupt stays high until software writes anything to the clear register.

A load write also copies the value straight into the counter, so a freshly programmed period starts cleanly. With a start value N the channel underflows once every N+1 selected ticks. Counter width is a parameter (16 or 32 bits). Bus data and address widths are parameters as well.

Top module: `down_timer`

## Requirements
- R1: After reset the control register, counter, start value and interrupt are all zero, so a read of offset 0x08 or 0x04 returns 0 and `irq` is low.
- R2: A write to offset 0x00 stores the low counter-width bits of the data as the start value and copies them into the counter on the same edge. Offset 0x00 reads back the start value, and offset 0x04 reads the live counter.
- R3: While control bit 7 is set, each selected tick lowers a nonzero counter by exactly one. While bit 7 is clear (including after a control write of zero), the counter holds.
- R4: Control bit 3 = 1 selects `tick_fast` as the counting tick, and bit 3 = 0 selects `tick_slow`. The unselected input has no effect on the counter.
- R5: With bit 6 = 1 (periodic), a selected tick at counter value zero reloads the counter from the start value and sets `irq`.
- R6: With bit 6 = 0 (free), a selected tick at counter value zero wraps the counter to all ones and sets `irq`.
- R7: A write of any data to offset 0x0C clears `irq` on the next edge. When an underflow happens on the same edge, `irq` stays high.
- R8: Offset 0x08 reads back only bits 7, 6 and 3 of the last control write, with every other bit zero. Offset 0x0C and any unmapped offset read zero.
- R9: A 32-bit channel accepts a start value of 0xFFFFFFFF and counts down from it.
- R10: Once set, `irq` stays high on every edge that carries no clear write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | AW (8) | Byte offset of the register |
| bus_we | input | 1 | Write strobe, one write per asserted cycle |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data for `bus_addr`, combinational |
| tick_fast | input | 1 | Fast count enable, one clock wide per tick |
| tick_slow | input | 1 | Slow count enable, one clock wide per tick |
| irq | output | 1 | Level interrupt on underflow |

## Verification
The assertions assume that the tick inputs and bus signals are synchronous to `clk`, with known values from reset onward. They also assume that a tick is a single-cycle enable and not a clock. The bench changes every input only on the falling edge. It draws ticks and writes at random from a fixed seed, and it keeps start values small so that underflows, reloads, wraps and clear-versus-underflow collisions occur often. Directed steps then cover the all-ones start value and the exact collision edge.

// File: rtl/down_timer.sv
module down_timer #(
  parameter int CW = 32,
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          tick_fast,
  input  logic          tick_slow,
  output logic          irq
);
  localparam logic [AW-1:0] OFS_START = AW'(8'h00);
  localparam logic [AW-1:0] OFS_COUNT = AW'(8'h04);
  localparam logic [AW-1:0] OFS_CTRL  = AW'(8'h08);
  localparam logic [AW-1:0] OFS_ACK   = AW'(8'h0C);
  localparam int BIT_RUN  = 7;
  localparam int BIT_PER  = 6;
  localparam int BIT_FAST = 3;

  logic [CW-1:0] start_q, count_q;
  logic          run_q, per_q, fast_q;

  wire start_wr = bus_we && bus_addr == OFS_START;
  wire ctrl_wr  = bus_we && bus_addr == OFS_CTRL;
  wire ack_wr   = bus_we && bus_addr == OFS_ACK;
  wire step     = run_q && (fast_q ? tick_fast : tick_slow);
  wire at_zero  = count_q == '0;
  wire underflow = step && at_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      count_q <= '0;
      run_q   <= 1'b0;
      per_q   <= 1'b0;
      fast_q  <= 1'b0;
      irq     <= 1'b0;
    end else begin
      if (start_wr) begin
        start_q <= bus_wdata[CW-1:0];
        count_q <= bus_wdata[CW-1:0];
      end else if (step) begin
        count_q <= at_zero ? (per_q ? start_q : '1) : count_q - 1'b1;
      end
      if (ctrl_wr) begin
        run_q  <= bus_wdata[BIT_RUN];
        per_q  <= bus_wdata[BIT_PER];
        fast_q <= bus_wdata[BIT_FAST];
      end
      if (underflow)   irq <= 1'b1;
      else if (ack_wr) irq <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_START: bus_rdata = DW'(start_q);
      OFS_COUNT: bus_rdata = DW'(count_q);
      OFS_CTRL: begin
        bus_rdata[BIT_RUN]  = run_q;
        bus_rdata[BIT_PER]  = per_q;
        bus_rdata[BIT_FAST] = fast_q;
      end
      default: bus_rdata = '0;
    endcase
  end

  // R2: a start-value write lands in the counter
  p_start_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr |=> count_q == $past(bus_wdata[CW-1:0]));
  // R3: disabled channel holds its count
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !start_wr) |=> $stable(count_q));
  // R3: one step per tick
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !at_zero && !start_wr) |=> count_q == $past(count_q) - 1'b1);
  // R5 / R6: underflow raises the interrupt
  p_irq_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> irq);
  // R6: free mode wraps to all ones
  p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && !per_q && !start_wr) |=> &count_q);
  // R10: interrupt is sticky without a clear write
  p_irq_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ack_wr) |=> irq);
  // R7: a clear write without an underflow drops the interrupt
  p_irq_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && !underflow) |=> !irq);
endmodule

// File: tb/tb_down_timer.sv
module tb_down_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick_fast = 1'b0, tick_slow = 1'b0;
  logic        irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  down_timer dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_fast(tick_fast),
    .tick_slow(tick_slow), .irq(irq));

  // reference model built from the requirements
  logic [31:0] m_start, m_cnt;
  logic m_run, m_per, m_fast, m_irq;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_start <= 0; m_cnt <= 0; m_run <= 0; m_per <= 0; m_fast <= 0; m_irq <= 0;
    end else begin
      automatic bit tk = m_run && (m_fast ? tick_fast : tick_slow);
      automatic bit uf = tk && m_cnt == 0;
      if (bus_we && bus_addr == 8'h00) begin m_start <= bus_wdata; m_cnt <= bus_wdata; end
      else if (tk) m_cnt <= (m_cnt == 0) ? (m_per ? m_start : 32'hFFFF_FFFF) : m_cnt - 1;
      if (bus_we && bus_addr == 8'h08) begin
        m_run <= bus_wdata[7]; m_per <= bus_wdata[6]; m_fast <= bus_wdata[3];
      end
      if (uf) m_irq <= 1;
      else if (bus_we && bus_addr == 8'h0C) m_irq <= 0;
    end
  end

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    case (a)
      8'h00: return m_start;
      8'h04: return m_cnt;
      8'h08: return {24'h0, m_run, m_per, 2'b00, m_fast, 3'b000};
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, input string req, input logic [31:0] exp);
    bus_addr = a; bus_we = 0;
    #2 check(req, bus_rdata, exp);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1; bus_wdata = d; tick_fast = 0; tick_slow = 0;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic ticks(input bit f, input bit s, input int n);
    for (int i = 0; i < n; i++) begin
      tick_fast = f; tick_slow = s;
      @(negedge clk);
    end
    tick_fast = 0; tick_slow = 0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(8'h08, "R1 ctrl", 0);
    rd(8'h04, "R1 count", 0);
    check("R1 irq", {31'h0, irq}, 0);

    wr(8'h00, 32'd5);
    rd(8'h00, "R2 start", 5);
    rd(8'h04, "R2 count", 5);

    wr(8'h08, 32'hC8);
    ticks(1, 0, 3);
    rd(8'h04, "R3 fast count", 2);
    ticks(0, 1, 3);
    rd(8'h04, "R4 slow ignored", 2);
    wr(8'h08, 32'hC0);
    ticks(0, 1, 2);
    rd(8'h04, "R4 slow count", 0);
    ticks(1, 0, 3);
    rd(8'h04, "R4 fast ignored", 0);
    check("R5 no irq yet", {31'h0, irq}, 0);
    ticks(0, 1, 1);
    rd(8'h04, "R5 reload", 5);
    check("R5 irq", {31'h0, irq}, 1);
    ticks(0, 0, 4);
    check("R10 irq sticky", {31'h0, irq}, 1);
    wr(8'h0C, 32'h0);
    check("R7 cleared", {31'h0, irq}, 0);

    wr(8'h08, 32'h88);
    wr(8'h00, 32'd1);
    ticks(1, 0, 2);
    rd(8'h04, "R6 wrap", 32'hFFFF_FFFF);
    check("R6 irq", {31'h0, irq}, 1);
    wr(8'h0C, 32'h5A5A);
    wr(8'h00, 32'd0);
    @(negedge clk);
    bus_addr = 8'h0C; bus_we = 1; tick_fast = 1;
    @(negedge clk);
    bus_we = 0; tick_fast = 0;
    check("R7 underflow wins", {31'h0, irq}, 1);

    wr(8'h08, 32'h0);
    wr(8'h00, 32'd9);
    ticks(1, 1, 4);
    rd(8'h04, "R3 stopped", 9);
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, "R8 ctrl mask", 32'hC8);
    rd(8'h0C, "R8 clear reads 0", 0);
    rd(8'h10, "R8 unmapped", 0);
    rd(8'h05, "R8 unaligned", 0);

    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h04, "R9 full load", 32'hFFFF_FFFF);
    ticks(1, 0, 1);
    rd(8'h04, "R9 count down", 32'hFFFF_FFFE);

    for (int c = 0; c < 4000; c++) begin
      automatic int r = $urandom % 16;
      tick_fast = 1'($urandom); tick_slow = 1'($urandom);
      bus_we = 0;
      if (r == 0) begin bus_we = 1; bus_addr = 8'h00; bus_wdata = $urandom % 6; end
      else if (r == 1) begin bus_we = 1; bus_addr = 8'h08; bus_wdata = $urandom; end
      else if (r == 2) begin bus_we = 1; bus_addr = 8'h0C; bus_wdata = $urandom; end
      else bus_addr = 8'(($urandom % 5) * 4);
      @(negedge clk);
      bus_we = 0;
      #2;
      check((bus_addr == 8'h04) ? "R3 random count" : "R8 random read",
            bus_rdata, exp_read(bus_addr));
      check("R7 random irq", {31'h0, irq}, {31'h0, m_irq});
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule